// File: doc/BRIEF.md
# Dual-Port Banked Memory Arbiter

This block sits in front of an internal data memory that is split into several single-ported banks of 64-bit words. Two data ports each present at most one load or store per cycle. The block maps each word address to a bank and lets both requests through in the same cycle when they land in different banks. When both requests need the same bank, it serves one, holds the other back for one cycle and raises `stall` so the issuing pipeline can freeze.

Each request channel is valid/ready. A port raises `x_valid` with its command fields and must hold them unchanged until it sees `x_ready` high in the same cycle. The block raises `x_ready` only while `x_valid` is high, and ready may depend on valid in the same cycle. A transfer happens on the rising edge where both are high. Load data comes back on a separate return channel with a fixed latency and no back-pressure. `b_first` is a plain control input: when high, it marks the port B request as the older one in program order. On a same-bank clash this sets which request is served first, and so whether a load sees a store's old or new data.

Top module: `mbank_dual`

## Requirements
- R1: The word address selects the bank through its low 3 bits. The remaining upper 6 bits select the row inside that bank. A bank is accessed by at most one port per cycle.
- R2: When both ports are valid and their bank fields differ, both `a_ready` and `b_ready` are high in that cycle and `stall` is low.
- R3: When both ports are valid and target the same bank, `stall` is high and exactly one ready is high. With `b_first` = 0 and no request owed from the previous cycle, port A is the one served.
- R4: A request that lost a clash is served in the next cycle ahead of the other port. If the other port then presents a new request to the same bank, that new request waits and `stall` is high again.
- R5: With `b_first` = 1 on a fresh clash, port B is served first and port A in the following cycle.
- R6: When a load is ordered before a store to the same word, the load returns the data held before the store.
- R7: When a store is ordered before a load to the same word, the load returns the stored data.
- R8: For an accepted load, `x_rvalid` is high for exactly one cycle, 4 rising edges after the accept edge, with the word in `x_rdata`. Returns on each port arrive in request order.
- R9: Byte enable bit i (1 = write) covers write data bits [8i+7:8i]. Bytes whose enable is 0 keep their previous value.
- R10: `stall` is low whenever the two ports are not both valid. `stall` and both `x_rvalid` are low during reset.
- R11: An accepted store produces no `x_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| b_first | input | 1 | Port B request is older; B wins a fresh clash |
| a_valid | input | 1 | Port A request valid |
| a_ready | output | 1 | Port A request accepted this cycle |
| a_we | input | 1 | Port A store (1) or load (0) |
| a_waddr | input | 9 | Port A word address |
| a_wdata | input | 64 | Port A store data |
| a_be | input | 8 | Port A byte enables |
| a_rvalid | output | 1 | Port A load data valid |
| a_rdata | output | 64 | Port A load data |
| b_valid | input | 1 | Port B request valid |
| b_ready | output | 1 | Port B request accepted this cycle |
| b_we | input | 1 | Port B store (1) or load (0) |
| b_waddr | input | 9 | Port B word address |
| b_wdata | input | 64 | Port B store data |
| b_be | input | 8 | Port B byte enables |
| b_rvalid | output | 1 | Port B load data valid |
| b_rdata | output | 64 | Port B load data |
| stall | output | 1 | Same-bank clash this cycle; one request held |

## Verification
The bench builds the block with its defaults: a 9-bit word address, 64-bit words, 8 banks and a load latency of 4. With these values all 512 words can be preloaded in 256 two-bank cycles, so every later load has a known expected value. Random word addresses limited to 64 words hit the same bank about one cycle in eight, which produces many clashes, owed requests and back-to-back clashes. The 4-stage return path keeps several loads in flight per port, so ordering and exact timing are checked while loads overlap.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  function automatic port_e other_port(input port_e p);
    return (p == PORT_A) ? PORT_B : PORT_A;
  endfunction
endpackage

// File: rtl/mbank_arb.sv
module mbank_arb
  import mbank_pkg::*;
#(
  parameter int BSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic              b_valid,
  input  logic [BSEL_W-1:0] a_bank,
  input  logic [BSEL_W-1:0] b_bank,
  input  logic              b_first,
  output logic              a_grant,
  output logic              b_grant,
  output logic              clash
);
  logic  owed_q;
  port_e owed_port_q;
  port_e win;

  always_comb begin
    clash = a_valid && b_valid && (a_bank == b_bank);
    if (owed_q) win = owed_port_q;
    else        win = b_first ? PORT_B : PORT_A;
    a_grant = a_valid && !(clash && (win == PORT_B));
    b_grant = b_valid && !(clash && (win == PORT_A));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q      <= 1'b0;
      owed_port_q <= PORT_A;
    end else begin
      owed_q      <= clash;
      owed_port_q <= other_port(win);
    end
  end
endmodule

// File: rtl/mbank_ram.sv
module mbank_ram #(
  parameter int DATA_W = 64,
  parameter int ROW_W  = 6
) (
  input  logic                clk,
  input  logic                en,
  input  logic                we,
  input  logic [ROW_W-1:0]    row,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   rdata
);
  localparam int BE_W = DATA_W / 8;
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < BE_W; i++) begin
          if (be[i]) mem[row][8*i +: 8] <= wdata[8*i +: 8];
        end
      end else begin
        rdata <= mem[row];
      end
    end
  end
endmodule

// File: rtl/mbank_ret.sv
module mbank_ret #(
  parameter int DATA_W = 64,
  parameter int NBANK  = 8,
  parameter int BSEL_W = 3,
  parameter int RD_LAT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [BSEL_W-1:0]           bank,
  input  logic [NBANK-1:0][DATA_W-1:0] bank_rd,
  output logic                        rvalid,
  output logic [DATA_W-1:0]           rdata
);
  logic              t_v;
  logic [BSEL_W-1:0] t_bank;
  logic [RD_LAT-1:0] v_q;
  logic [RD_LAT-1:0][DATA_W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v <= 1'b0;
      v_q <= '0;
    end else begin
      t_v    <= fire;
      v_q[0] <= t_v;
      for (int i = 1; i < RD_LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    t_bank <= bank;
    d_q[0] <= bank_rd[t_bank];
    for (int i = 1; i < RD_LAT; i++) d_q[i] <= d_q[i-1];
  end

  assign rvalid = v_q[RD_LAT-1];
  assign rdata  = d_q[RD_LAT-1];
endmodule

// File: rtl/mbank_dual.sv
module mbank_dual #(
  parameter int WADDR_W = 9,
  parameter int DATA_W  = 64,
  parameter int NBANK   = 8,
  parameter int RD_LAT  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                b_first,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic                a_we,
  input  logic [WADDR_W-1:0]  a_waddr,
  input  logic [DATA_W-1:0]   a_wdata,
  input  logic [DATA_W/8-1:0] a_be,
  output logic                a_rvalid,
  output logic [DATA_W-1:0]   a_rdata,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic                b_we,
  input  logic [WADDR_W-1:0]  b_waddr,
  input  logic [DATA_W-1:0]   b_wdata,
  input  logic [DATA_W/8-1:0] b_be,
  output logic                b_rvalid,
  output logic [DATA_W-1:0]   b_rdata,
  output logic                stall
);
  localparam int BSEL_W = $clog2(NBANK);
  localparam int ROW_W  = WADDR_W - BSEL_W;

  logic [BSEL_W-1:0] a_bank, b_bank;
  logic [ROW_W-1:0]  a_row, b_row;
  logic              a_grant, b_grant;
  logic [NBANK-1:0][DATA_W-1:0] bank_rd;

  assign a_bank = a_waddr[BSEL_W-1:0];
  assign b_bank = b_waddr[BSEL_W-1:0];
  assign a_row  = a_waddr[WADDR_W-1:BSEL_W];
  assign b_row  = b_waddr[WADDR_W-1:BSEL_W];

  mbank_arb #(.BSEL_W(BSEL_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_valid (a_valid),
    .b_valid (b_valid),
    .a_bank  (a_bank),
    .b_bank  (b_bank),
    .b_first (b_first),
    .a_grant (a_grant),
    .b_grant (b_grant),
    .clash   (stall)
  );

  assign a_ready = a_grant;
  assign b_ready = b_grant;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic use_a, use_b;
    assign use_a = a_grant && (a_bank == BSEL_W'(g));
    assign use_b = b_grant && (b_bank == BSEL_W'(g));

    mbank_ram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_ram (
      .clk   (clk),
      .en    (use_a || use_b),
      .we    (use_a ? a_we    : b_we),
      .row   (use_a ? a_row   : b_row),
      .wdata (use_a ? a_wdata : b_wdata),
      .be    (use_a ? a_be    : b_be),
      .rdata (bank_rd[g])
    );
  end

  mbank_ret #(.DATA_W(DATA_W), .NBANK(NBANK), .BSEL_W(BSEL_W), .RD_LAT(RD_LAT)) u_ret_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (a_grant && !a_we),
    .bank    (a_bank),
    .bank_rd (bank_rd),
    .rvalid  (a_rvalid),
    .rdata   (a_rdata)
  );

  mbank_ret #(.DATA_W(DATA_W), .NBANK(NBANK), .BSEL_W(BSEL_W), .RD_LAT(RD_LAT)) u_ret_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (b_grant && !b_we),
    .bank    (b_bank),
    .bank_rd (bank_rd),
    .rvalid  (b_rvalid),
    .rdata   (b_rdata)
  );
endmodule

// File: rtl/mbank_chk.sv
module mbank_chk #(
  parameter int BSEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic              a_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic [BSEL_W-1:0] a_bank,
  input logic [BSEL_W-1:0] b_bank,
  input logic              stall
);
  p_one_per_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && b_valid && b_ready) |-> (a_bank != b_bank));

  p_parallel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && (a_bank != b_bank)) |-> (a_ready && b_ready && !stall));

  p_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && (a_bank == b_bank)) |-> (stall && ($countones({a_ready, b_ready}) == 1)));

  p_owed_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && b_valid && !b_ready) |=> (b_valid |-> b_ready));

  p_owed_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && a_valid && !a_ready) |=> (a_valid |-> a_ready));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && b_valid) |-> !stall);
endmodule

bind mbank_dual mbank_chk #(.BSEL_W(BSEL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_valid (a_valid),
  .a_ready (a_ready),
  .b_valid (b_valid),
  .b_ready (b_ready),
  .a_bank  (a_bank),
  .b_bank  (b_bank),
  .stall   (stall)
);

// File: tb/tb_mbank_dual.sv
module tb_mbank_dual;
  localparam int LAT = 4;

  logic        clk, rst_n, b_first;
  logic        a_valid, a_ready, a_we, a_rvalid;
  logic [8:0]  a_waddr;
  logic [63:0] a_wdata, a_rdata;
  logic [7:0]  a_be;
  logic        b_valid, b_ready, b_we, b_rvalid;
  logic [8:0]  b_waddr;
  logic [63:0] b_wdata, b_rdata;
  logic [7:0]  b_be;
  logic        stall;

  mbank_dual dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0, rv_cnt = 0;
  bit done = 0;

  logic [63:0] mdl [512];
  bit owed = 0, owed_b = 0;
  logic [63:0] qa_d[$], qb_d[$];
  int          qa_t[$], qb_t[$];

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int w);
    return 64'hA5A5_0000_0000_0000 ^ (64'(w) * 64'h0001_0003_0007_000B);
  endfunction

  function automatic logic [31:0] nx(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d, input logic [7:0] be);
    logic [63:0] r = old;
    for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // one request cycle on both ports; expected accepts come from R2..R5
  task automatic step(input bit av, input bit aw, input logic [8:0] aa, input logic [63:0] ad, input logic [7:0] abe,
                      input bit bv, input bit bw, input logic [8:0] ba, input logic [63:0] bd, input logic [7:0] bbe,
                      input bit bf, output bit acc_a, output bit acc_b, input string tag);
    bit coll, pb;
    @(negedge clk);
    a_valid = av; a_we = aw; a_waddr = aa; a_wdata = ad; a_be = abe;
    b_valid = bv; b_we = bw; b_waddr = ba; b_wdata = bd; b_be = bbe;
    b_first = bf;
    #1;
    coll  = av && bv && (aa[2:0] == ba[2:0]);
    pb    = owed ? owed_b : bf;
    acc_a = av && !(coll && pb);
    acc_b = bv && !(coll && !pb);
    chk(a_ready == acc_a, {tag, " a_ready"}, 64'(a_ready), 64'(acc_a));
    chk(b_ready == acc_b, {tag, " b_ready"}, 64'(b_ready), 64'(acc_b));
    chk(stall == coll, {tag, " stall"}, 64'(stall), 64'(coll));
    if (acc_a) begin
      if (aw) mdl[aa] = merge(mdl[aa], ad, abe);
      else begin qa_d.push_back(mdl[aa]); qa_t.push_back(cyc + 1 + LAT); end
    end
    if (acc_b) begin
      if (bw) mdl[ba] = merge(mdl[ba], bd, bbe);
      else begin qb_d.push_back(mdl[ba]); qb_t.push_back(cyc + 1 + LAT); end
    end
    owed   = coll;
    owed_b = !pb;
  endtask

  task automatic idle(input int n);
    bit x, y;
    for (int i = 0; i < n; i++) step(0,0,0,0,0, 0,0,0,0,0, 0, x, y, "idle");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_rvalid) begin
        rv_cnt++;
        if (qa_d.size() == 0) chk(0, "R11 unexpected a_rvalid", 64'(1), 64'(0));
        else begin
          logic [63:0] e; int t;
          e = qa_d.pop_front(); t = qa_t.pop_front();
          chk(a_rdata == e, "R1/R6/R7/R9 port A data", a_rdata, e);
          chk(t == cyc, "R8 port A return cycle", 64'(cyc), 64'(t));
        end
      end else if (qa_t.size() != 0 && qa_t[0] <= cyc) begin
        chk(0, "R8 port A return missing", 64'(0), 64'(1));
        void'(qa_d.pop_front()); void'(qa_t.pop_front());
      end
      if (b_rvalid) begin
        rv_cnt++;
        if (qb_d.size() == 0) chk(0, "R11 unexpected b_rvalid", 64'(1), 64'(0));
        else begin
          logic [63:0] e; int t;
          e = qb_d.pop_front(); t = qb_t.pop_front();
          chk(b_rdata == e, "R1/R6/R7/R9 port B data", b_rdata, e);
          chk(t == cyc, "R8 port B return cycle", 64'(cyc), 64'(t));
        end
      end else if (qb_t.size() != 0 && qb_t[0] <= cyc) begin
        chk(0, "R8 port B return missing", 64'(0), 64'(1));
        void'(qb_d.pop_front()); void'(qb_t.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit x, y;
    logic [31:0] seed;
    int n0;
    rst_n = 0; b_first = 0;
    a_valid = 0; a_we = 0; a_waddr = 0; a_wdata = 0; a_be = 0;
    b_valid = 0; b_we = 0; b_waddr = 0; b_wdata = 0; b_be = 0;
    repeat (3) @(negedge clk);
    chk(stall == 0, "R10 stall in reset", 64'(stall), 0);
    chk(a_rvalid == 0 && b_rvalid == 0, "R10 rvalid in reset", 64'({a_rvalid, b_rvalid}), 0);
    rst_n = 1;

    // R2: fill every word, A on even banks, B on odd banks; R11 no returns
    n0 = rv_cnt;
    for (int k = 0; k < 256; k++)
      step(1,1,9'(2*k),pat(2*k),8'hFF, 1,1,9'(2*k+1),pat(2*k+1),8'hFF, 0, x, y, "R2 fill");
    idle(LAT + 2);
    chk(rv_cnt == n0, "R11 stores gave no returns", 64'(rv_cnt), 64'(n0));

    // R1/R2/R8: parallel loads on distinct banks
    for (int k = 0; k < 8; k++)
      step(1,0,9'(9*k),0,0, 1,0,9'(8*k + (k+3)%8),0,0, 0, x, y, "R2 parallel load");
    idle(LAT + 2);

    // R3 then R4: clash on bank 0, A first, B next cycle
    step(1,0,9'd16,0,0, 1,0,9'd24,0,0, 0, x, y, "R3 clash A wins");
    step(0,0,0,0,0,     1,0,9'd24,0,0, 0, x, y, "R4 owed B served");
    idle(2);

    // R5: b_first gives B the first slot
    step(1,0,9'd33,0,0, 1,0,9'd41,0,0, 1, x, y, "R5 clash B wins");
    step(1,0,9'd33,0,0, 0,0,0,0,0,     0, x, y, "R5 owed A served");
    idle(2);

    // R6: load (A) ordered before store (B) to word 50 returns old data
    step(1,0,9'd50,0,0, 1,1,9'd50,64'h1111_2222_3333_4444,8'hFF, 0, x, y, "R6 load first");
    step(0,0,0,0,0,     1,1,9'd50,64'h1111_2222_3333_4444,8'hFF, 0, x, y, "R6 store second");
    step(1,0,9'd50,0,0, 0,0,0,0,0, 0, x, y, "R6 reload");
    idle(2);

    // R7: store (B) ordered before load (A) to word 60 returns new data
    step(1,0,9'd60,0,0, 1,1,9'd60,64'hDEAD_BEEF_0BAD_F00D,8'hFF, 1, x, y, "R7 store first");
    step(1,0,9'd60,0,0, 0,0,0,0,0, 0, x, y, "R7 load second");
    idle(2);
    // R7: store on A before load on B, default order
    step(1,1,9'd61,64'h0123_4567_89AB_CDEF,8'hFF, 1,0,9'd61,0,0, 0, x, y, "R7 A store first");
    step(0,0,0,0,0, 1,0,9'd61,0,0, 0, x, y, "R7 B load second");
    idle(2);

    // R4: owed B beats a new colliding A request
    step(1,0,9'd2,0,0,  1,0,9'd10,0,0, 0, x, y, "R4 clash one");
    step(1,0,9'd18,0,0, 1,0,9'd10,0,0, 0, x, y, "R4 owed B vs new A");
    step(1,0,9'd18,0,0, 0,0,0,0,0,     0, x, y, "R4 A served last");
    idle(2);

    // R9: partial stores
    step(1,1,9'd70,64'hFFFF_FFFF_FFFF_FFFF,8'b0000_0101, 1,1,9'd71,64'h0,8'b1000_0000, 0, x, y, "R9 partial store");
    step(1,0,9'd70,0,0, 1,0,9'd71,0,0, 0, x, y, "R9 readback");
    idle(LAT + 2);

    // mixed random traffic within 64 words
    begin
      bit ha = 0, hb = 0, pa_w = 0, pb_w = 0, bf;
      logic [8:0] pa_a = 0, pb_a = 0;
      logic [63:0] pa_d = 0, pb_d = 0;
      logic [7:0] pa_be = 0, pb_be = 0;
      seed = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
        if (!ha) begin
          seed = nx(seed);
          pa_w = seed[0]; pa_a = {3'b0, seed[9:4]}; pa_d = {seed, ~seed}; pa_be = seed[31:24];
          ha = 1;
        end
        if (!hb) begin
          seed = nx(seed);
          pb_w = seed[1]; pb_a = {3'b0, seed[15:10]}; pb_d = {~seed, seed}; pb_be = seed[23:16];
          hb = 1;
        end
        seed = nx(seed);
        bf = seed[3];
        step(1,pa_w,pa_a,pa_d,pa_be, 1,pb_w,pb_a,pb_d,pb_be, bf, x, y, "R3/R4/R5 random");
        if (x) ha = 0;
        if (y) hb = 0;
      end
    end
    idle(LAT + 3);
    chk(qa_d.size() == 0 && qb_d.size() == 0, "R8 all loads returned",
        64'(qa_d.size() + qb_d.size()), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule